// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a memory-mapped bank of 32 general-purpose lines, arranged as four ports of eight lines each, behind a 32-bit register interface. Software sets each line as an input or an output and writes output levels through a data register. Reading that register returns the synchronized pin level for input lines and the latched output value for output lines.

Each line has a 2-bit interrupt mode that both enables the line and selects which edge it reacts to. Pin inputs pass through a two-flop synchronizer, and edges are detected after that. A detected edge sets a pending flag, which stays set until software writes a one to that bit. All pending flags are ORed into one interrupt output. A small array of per-CPU enable masks also routes pending flags to separate per-CPU interrupt outputs.

A build-time parameter selects the port byte order. It applies to both the one-bit-per-line registers and the two-bit mode registers.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, direction, output latch, both mode words, status and every per-CPU mask read 0, and `pin_oe`, `irq` and `cpu_irq` are 0.
- R2: `pin_oe[n]` equals direction bit n and `pin_out[n]` equals output latch bit n. A direction bit of 1 means output. Writes to word address 3 update only the output latch.
- R3: Reading word address 3 returns, for each line, the latch bit if the line is an output and the synchronized pin level if it is an input. A pin change is visible there after two clock edges.
- R4: The mode code per line is 0 = off, 1 = falling edge, 2 = rising edge, 3 = both. A line in mode 0 never sets its pending flag. A qualifying edge sets the flag on the third clock edge after the pin changes.
- R5: With normal order (`REVERSED=0`), line n uses bit n in the 1-bit registers. Line n (port p = n/8, pin i = n%8) has its mode field at bit position 2*(8*(p XOR 1)+i) of a 64-bit value. Word address 5 holds bits 31:0 of that value and word address 6 holds bits 63:32.
- R6: With `REVERSED=1`, port p occupies byte 3-p of the 1-bit registers, and the mode field of line n is at bit position 2*n of the same 64-bit value.
- R7: Writing word address 4 clears each pending flag whose data bit is 1. Bits written as 0 leave their flags unchanged. Reads of that address return the flags.
- R8: An edge that arrives in the same cycle as a clear of that line leaves the flag set.
- R9: `irq` is the OR of all pending flags. `cpu_irq[c]` is the OR of the pending flags ANDed with mask c.
- R10: Mask c is read and written at word address 8+c. It uses the same byte layout as the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 32 | Pin levels, asynchronous to `clk` |
| pin_out | output | 32 | Output latch, line-ordered |
| pin_oe | output | 32 | Output enable per line |
| irq | output | 1 | OR of all pending flags |
| cpu_irq | output | NUM_CPUS | Per-CPU masked interrupt |

## Verification
Register writes take effect at the clock edge that samples the strobe, and reads are combinational, so read-back is sampled half a cycle after the write. An input pin change appears in the data read after two clock edges. Its pending flag, and with it `irq` and `cpu_irq`, appear after three. The bench changes pins at a falling edge and then waits four cycles before comparing against its model. The set-versus-clear collision is timed by counting those edges exactly, so that the clear strobe lands on the third edge. Two instances, one per byte order, get the same line-ordered stimulus, and their reads are compared with layouts the bench packs on its own.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned PORTS    = 4;
  localparam int unsigned LINES    = PORT_W * PORTS;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] WA_DIR     = 4'd2;
  localparam logic [ADDR_W-1:0] WA_DATA    = 4'd3;
  localparam logic [ADDR_W-1:0] WA_STAT    = 4'd4;
  localparam logic [ADDR_W-1:0] WA_MODE_LO = 4'd5;
  localparam logic [ADDR_W-1:0] WA_MODE_HI = 4'd6;

  // Byte permutation for one-bit-per-line words; it is its own inverse.
  function automatic logic [LINES-1:0] map_bits(input logic [LINES-1:0] v, input logic rev);
    logic [LINES-1:0] w;
    for (int p = 0; p < PORTS; p++)
      w[PORT_W*p +: PORT_W] = rev ? v[PORT_W*(PORTS-1-p) +: PORT_W] : v[PORT_W*p +: PORT_W];
    return w;
  endfunction

  // Port-pair permutation for the 64-bit mode image; also its own inverse.
  function automatic logic [2*LINES-1:0] map_modes(input logic [2*LINES-1:0] m, input logic rev);
    logic [2*LINES-1:0] w;
    for (int p = 0; p < PORTS; p++)
      w[MODE_W*PORT_W*(p ^ 1) +: MODE_W*PORT_W] = m[MODE_W*PORT_W*p +: MODE_W*PORT_W];
    return rev ? m : w;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;

  assert_level_follows_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (meta_q == sync_q) |=> (prev_q == level_o));
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(pend_o));
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int unsigned WIDTH    = 32,
  parameter int unsigned NUM_CPUS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WIDTH-1:0]          pend_i,
  input  logic [NUM_CPUS*WIDTH-1:0] mask_i,
  output logic [NUM_CPUS-1:0]       cpu_irq_o,
  output logic                      irq_o
);
  assign irq_o = |pend_i;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    assign cpu_irq_o[c] = |(pend_i & mask_i[WIDTH*c +: WIDTH]);
  end

  assert_cpu_implies_any_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq_o != '0) |-> irq_o);
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_CPUS = 2,
  parameter bit          REVERSED = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [3:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [31:0]         pin_in,
  output logic [31:0]         pin_out,
  output logic [31:0]         pin_oe,
  output logic                irq,
  output logic [NUM_CPUS-1:0] cpu_irq
);
  localparam int unsigned MW = MODE_W * LINES;

  logic [LINES-1:0]          dir_q, out_q;
  logic [MW-1:0]             mode_phys_q;
  logic [NUM_CPUS*LINES-1:0] mask_q;
  logic [MW-1:0]             mode_ln;
  logic [LINES-1:0]          level, rise, fall, set_ev, clr_ev, pend, mode_off;
  logic [LINES-1:0]          wr_ln, data_ln;
  logic                      wr_dir, wr_data, wr_stat, wr_mlo, wr_mhi, cpu_sel;
  logic [2:0]                cpu_idx;

  assign wr_ln   = map_bits(bus_wdata, REVERSED);
  assign wr_dir  = bus_wr && bus_addr == WA_DIR;
  assign wr_data = bus_wr && bus_addr == WA_DATA;
  assign wr_stat = bus_wr && bus_addr == WA_STAT;
  assign wr_mlo  = bus_wr && bus_addr == WA_MODE_LO;
  assign wr_mhi  = bus_wr && bus_addr == WA_MODE_HI;
  assign cpu_idx = bus_addr[2:0];
  assign cpu_sel = bus_addr[3] && (32'(cpu_idx) < NUM_CPUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q       <= '0;
      out_q       <= '0;
      mode_phys_q <= '0;
    end else begin
      if (wr_dir)  dir_q <= wr_ln;
      if (wr_data) out_q <= wr_ln;
      if (wr_mlo)  mode_phys_q[31:0]  <= bus_wdata;
      if (wr_mhi)  mode_phys_q[63:32] <= bus_wdata;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[LINES*c +: LINES] <= '0;
      else if (bus_wr && cpu_sel && 32'(cpu_idx) == c) mask_q[LINES*c +: LINES] <= wr_ln;
    end
  end

  assign mode_ln = map_modes(mode_phys_q, REVERSED);

  gpio_in_sync #(.WIDTH(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign set_ev[n]   = (rise[n] & mode_ln[MODE_W*n+1]) | (fall[n] & mode_ln[MODE_W*n]);
    assign mode_off[n] = mode_ln[MODE_W*n +: MODE_W] == 2'd0;
  end

  assign clr_ev = wr_stat ? wr_ln : '0;

  gpio_pend #(.WIDTH(LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(set_ev), .clr_i(clr_ev), .pend_o(pend)
  );

  gpio_irq_route #(.WIDTH(LINES), .NUM_CPUS(NUM_CPUS)) u_route (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask_q),
    .cpu_irq_o(cpu_irq), .irq_o(irq)
  );

  assign data_ln = (dir_q & out_q) | (~dir_q & level);
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    bus_rdata = '0;
    if (cpu_sel) bus_rdata = map_bits(mask_q[LINES*cpu_idx +: LINES], REVERSED);
    else begin
      case (bus_addr)
        WA_DIR:     bus_rdata = map_bits(dir_q, REVERSED);
        WA_DATA:    bus_rdata = map_bits(data_ln, REVERSED);
        WA_STAT:    bus_rdata = map_bits(pend, REVERSED);
        WA_MODE_LO: bus_rdata = mode_phys_q[31:0];
        WA_MODE_HI: bus_rdata = mode_phys_q[63:32];
        default:    bus_rdata = '0;
      endcase
    end
  end

  assert_off_never_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & $past(mode_off)) == '0));
  assert_latch_only_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(pin_out));
  assert_dir_only_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pin_oe));
endmodule

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
  localparam int NC = 2;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] wd0 = '0, wd1 = '0, rd0, rd1, pin_in = '0;
  logic [31:0] pout0, poe0, pout1, poe1;
  logic irq0, irq1;
  logic [NC-1:0] cirq0, cirq1;
  int tests = 0, fails = 0;
  bit done = 0;

  logic [31:0] dir_m = 0, out_m = 0, pend_m = 0, pin_m = 0;
  logic [63:0] mode_m = 0;
  logic [31:0] mask_m [NC];

  always #2.5 clk = ~clk;

  gpio_edge_bank #(.NUM_CPUS(NC), .REVERSED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(wd0),
    .bus_rdata(rd0), .pin_in(pin_in), .pin_out(pout0), .pin_oe(poe0), .irq(irq0), .cpu_irq(cirq0));
  gpio_edge_bank #(.NUM_CPUS(NC), .REVERSED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(wd1),
    .bus_rdata(rd1), .pin_in(pin_in), .pin_out(pout1), .pin_oe(poe1), .irq(irq1), .cpu_irq(cirq1));

  function automatic logic [31:0] pk1(input logic [31:0] v, input bit rev);
    logic [31:0] w = '0;
    for (int n = 0; n < 32; n++) begin
      int b = rev ? 8 * (3 - n / 8) + n % 8 : n;
      w[b] = v[n];
    end
    return w;
  endfunction

  function automatic logic [63:0] pkm(input logic [63:0] m, input bit rev);
    logic [63:0] w = '0;
    for (int n = 0; n < 32; n++) begin
      int b = rev ? 2 * n : 2 * (8 * ((n / 8) ^ 1) + n % 8);
      w[b +: 2] = m[2*n +: 2];
    end
    return w;
  endfunction

  function automatic logic [31:0] edges(input logic [31:0] o, input logic [31:0] v, input logic [63:0] m);
    logic [31:0] s = '0;
    for (int n = 0; n < 32; n++)
      s[n] = (m[2*n+1] & v[n] & ~o[n]) | (m[2*n] & ~v[n] & o[n]);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v0, input logic [31:0] v1);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; wd0 = v0; wd1 = v1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic wr1(input logic [3:0] a, input logic [31:0] v);
    wr(a, pk1(v, 0), pk1(v, 1));
  endtask

  task automatic wrmode(input logic [63:0] m);
    wr(4'd5, pkm(m, 0) [31:0],  pkm(m, 1) [31:0]);
    wr(4'd6, pkm(m, 0) [63:32], pkm(m, 1) [63:32]);
    mode_m = m;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    bus_addr = a;
    #1;
    r0 = rd0; r1 = rd1;
  endtask

  task automatic chk1(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] r0, r1;
    rd(a, r0, r1);
    chk({tag, " normal"}, r0, pk1(exp, 0));
    chk({tag, " reversed"}, r1, pk1(exp, 1));
  endtask

  task automatic setpins(input logic [31:0] v);
    @(negedge clk);
    pend_m = pend_m | edges(pin_m, v, mode_m);
    pin_in = v; pin_m = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] ec;
    chk1({tag, " R3 data"}, 4'd3, (dir_m & out_m) | (~dir_m & pin_m));
    chk1({tag, " R7 status"}, 4'd4, pend_m);
    chk({tag, " R2 oe"}, poe0 ^ poe1 ^ poe0, dir_m);
    chk({tag, " R2 out"}, pout1, out_m);
    chk({tag, " R9 irq"}, {30'd0, irq1, irq0}, {30'd0, |pend_m, |pend_m});
    ec = '0;
    for (int c = 0; c < NC; c++) ec[c] = |(pend_m & mask_m[c]);
    chk({tag, " R9 cpu_irq"}, {30'd0, cirq0}, ec);
    chk({tag, " R9 cpu_irq rev"}, {30'd0, cirq1}, ec);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r0, r1;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NC; c++) mask_m[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk1("R1 dir", 4'd2, 0);
    chk1("R1 stat", 4'd4, 0);
    chk1("R1 mode lo", 4'd5, 0);
    chk1("R1 mode hi", 4'd6, 0);
    chk1("R1 mask0", 4'd8, 0);
    chk1("R1 mask1", 4'd9, 0);
    chk("R1 oe", poe0 | poe1, 0);
    chk("R1 irq", {30'd0, cirq0 | cirq1} | {31'd0, irq0 | irq1}, 0);

    // R5 / R6 mode field placement
    wrmode(64'h3 | (64'h2 << 62));
    rd(4'd5, r0, r1);
    chk("R5 line0 lo", r0, 32'h0003_0000);
    chk("R6 line0 lo", r1, 32'h0000_0003);
    rd(4'd6, r0, r1);
    chk("R5 line31 hi", r0, 32'h0000_8000);
    chk("R6 line31 hi", r1, 32'h8000_0000);
    wrmode(64'h0);

    // R6 / R2 one-bit layout
    wr1(4'd2, 32'h1); dir_m = 32'h1;
    rd(4'd2, r0, r1);
    chk("R5 dir bit0", r0, 32'h0000_0001);
    chk("R6 dir bit0", r1, 32'h0100_0000);
    chk("R2 oe line0", poe0 & poe1, 32'h1);
    wr1(4'd3, 32'h0000_0101); out_m = 32'h0000_0101;
    check_all("R2 latch");

    // R4 mode codes: line1 rise, line2 fall, line3 both, line4 off
    wrmode(64'h0 | (64'h2 << 2) | (64'h1 << 4) | (64'h3 << 6));
    setpins(32'h0000_001E);
    chk("R4 after rise", pend_m, 32'h0000_000A);
    check_all("R4 rise");
    setpins(32'h0);
    check_all("R4 fall");

    // R7 write zero does nothing, write one clears
    wr1(4'd4, 32'h0);
    check_all("R7 zero write");
    wr1(4'd4, 32'h0000_0008); pend_m &= ~32'h8;
    check_all("R7 clear one");

    // R10 / R9 per-CPU masks
    wr1(4'd8, 32'h0000_0004); mask_m[0] = 32'h4;
    wr1(4'd9, 32'h0000_0800); mask_m[1] = 32'h800;
    rd(4'd9, r0, r1);
    chk("R10 mask1 normal", r0, 32'h0000_0800);
    chk("R10 mask1 reversed", r1, 32'h0008_0000);
    check_all("R10 masks");

    // R8 edge in same cycle as its clear (line 5, both edges)
    wrmode(64'h3 << 10);
    setpins(32'h0000_0020);
    check_all("R8 prep");
    @(negedge clk);
    pin_in = 32'h0; pin_m = 32'h0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4'd4; wd0 = pk1(32'h20, 0); wd1 = pk1(32'h20, 1);
    @(negedge clk);
    bus_wr = 0;
    repeat (2) @(negedge clk);
    check_all("R8 collide");
    wr1(4'd4, 32'h20); pend_m &= ~32'h20;
    check_all("R8 later clear");

    // Random phase
    for (int it = 0; it < 80; it++) begin
      int op = $urandom_range(0, 5);
      logic [31:0] v = $urandom;
      case (op)
        0: begin wr1(4'd2, v); dir_m = v; end
        1: begin wr1(4'd3, v); out_m = v; end
        2: wrmode({$urandom, $urandom});
        3: setpins(v);
        4: begin wr1(4'd4, v); pend_m &= ~v; end
        default: begin
          int c = $urandom_range(0, NC - 1);
          wr1(4'(8 + c), v); mask_m[c] = v;
        end
      endcase
      check_all($sformatf("rand%0d", it));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule